// File: doc/BRIEF.md
# Double-Rate Pin Register with Selectable Bit Alignment

This block sits between a group of pins and the core logic. On the receive side it samples each pin line on both clock edges. It hands the two samples to the core as one pair per clock cycle. On the transmit side it accepts a pair per clock cycle from the core and drives the first bit during the high phase of the clock and the second bit during the low phase. The core-side buses are twice as wide as the pin buses. They are packed by time slot: the lower half holds the bit of the rising-edge slot and the upper half holds the bit of the falling-edge slot.

Three alignments can be chosen separately for each direction, each set by a parameter:

- **Opposite-edge** keeps each bit on its own edge.
- **Same-edge** moves all fabric-side activity to the rising edge.
- **Pipelined same-edge** adds one register stage, so that both bits of one pin pair move together on a single rising edge.

Further parameters control the rest of the interface:

- A parameter chooses between an asynchronous reset and a reset synchronous to the clock.
- A parameter decides whether the clock-enable input is honoured or ignored.

All core-facing pins are plain registered signals without a handshake. The pin timing cannot stall, so there is no back-pressure.

Top module: `ddr_align_io`

## Requirements
- R1: `rx_pair[W-1:0]` carries the sample taken at a rising edge and `rx_pair[2W-1:W]` the sample taken at the following falling edge. `tx_pair[W-1:0]` is driven on `pin_out` while `clk` is high and `tx_pair[2W-1:W]` while `clk` is low.
- R2: With input alignment opposite-edge (encoding 0), the low half of `rx_pair` updates at each rising edge and the high half updates at each falling edge, each with the sample just taken.
- R3: With input alignment same-edge (encoding 1), both halves update only at rising edges. The low half takes the sample of that edge and the high half takes the falling-edge sample from the half cycle before it.
- R4: With input alignment pipelined (encoding 2), both halves update at a rising edge and together show the rising and falling samples of the previous cycle.
- R5: With output alignment opposite-edge (encoding 0), the low half of `tx_pair` is sampled at the rising edge and the high half at the falling edge, each driven during the half cycle that follows.
- R6: With output alignment same-edge (encoding 1), both halves of `tx_pair` are sampled at a rising edge and driven high-phase then low-phase in that same cycle.
- R7: With output alignment pipelined (encoding 2), both halves are sampled at a rising edge and driven one full cycle later.
- R8: When `USE_CE` is 1 and `ce` is low at an edge, no register changes at that edge. Both `rx_pair` and the two phase values on `pin_out` hold.
- R9: When `USE_CE` is 0, `ce` has no effect and data keeps moving.
- R10: With the asynchronous reset type, raising `rst` clears every register, including pipeline stages, without waiting for a clock edge. `rx_pair` and `pin_out` then read 0.
- R11: With the synchronous reset type, `rst` clears the registers only at the next clock edge of each register.
- R12: By default the input alignment is pipelined, the output alignment is same-edge, the reset is asynchronous and `ce` is honoured.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; both edges carry data |
| rst | input | 1 | Active-high reset, asynchronous or synchronous by parameter |
| ce | input | 1 | Clock enable for every register when enabled by parameter |
| pin_in | input | W | Receive lines from the pins |
| rx_pair | output | 2W | Received pair: low half from the rising slot, high half from the falling slot |
| tx_pair | input | 2W | Pair to transmit: low half in the high phase, high half in the low phase |
| pin_out | output | W | Transmit lines to the pins |

## Verification
A wrong register in the receive path shows up as a pair that is skewed by half a cycle or a full cycle. A rising sample joined to the wrong falling sample is the typical symptom, and it is visible at the first rising edge after the fault. A wrong register in the transmit path swaps or delays the phase values on `pin_out`, which shows within one half cycle of the affected edge. A stage that was not cleared by reset, or that ignores the clock enable, leaks stale data onto the outputs at the first edge after reset release or while the enable is low.

// File: rtl/ddr_align_pkg.sv
package ddr_align_pkg;
  typedef enum logic [1:0] {
    ALIGN_OPP  = 2'd0,
    ALIGN_SAME = 2'd1,
    ALIGN_PIPE = 2'd2
  } align_e;
endpackage

// File: rtl/ddr_edge_reg.sv
module ddr_edge_reg #(
  parameter int W        = 1,
  parameter bit NEG_EDGE = 1'b0,
  parameter bit SYNC_RST = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  generate
    if (!NEG_EDGE && !SYNC_RST) begin : g_pos_async
      always_ff @(posedge clk or posedge rst)
        if (rst) q <= '0;
        else if (en) q <= d;
    end else if (!NEG_EDGE) begin : g_pos_sync
      always_ff @(posedge clk)
        if (rst) q <= '0;
        else if (en) q <= d;
    end else if (!SYNC_RST) begin : g_neg_async
      always_ff @(negedge clk or posedge rst)
        if (rst) q <= '0;
        else if (en) q <= d;
    end else begin : g_neg_sync
      always_ff @(negedge clk)
        if (rst) q <= '0;
        else if (en) q <= d;
    end

    if (!NEG_EDGE) begin : g_chk_pos
      AST_CE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q)) else $error("ce hold violated"); // R8
      AST_RST_ZERO: assert property (@(posedge clk)
        rst && $past(rst) |-> q == '0) else $error("reset not cleared"); // R10 R11
    end else begin : g_chk_neg
      AST_CE_HOLD: assert property (@(negedge clk) disable iff (rst)
        !en |=> $stable(q)) else $error("ce hold violated"); // R8
      AST_RST_ZERO: assert property (@(negedge clk)
        rst && $past(rst) |-> q == '0) else $error("reset not cleared"); // R10 R11
    end
  endgenerate
endmodule

// File: rtl/ddr_capture.sv
module ddr_capture
  import ddr_align_pkg::*;
#(
  parameter int     W        = 4,
  parameter align_e ALIGN    = ALIGN_PIPE,
  parameter bit     SYNC_RST = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [W-1:0]   pin_in,
  output logic [2*W-1:0] pair_out
);
  localparam int PW = 2 * W;

  logic [W-1:0] rise_q, fall_q;

  ddr_edge_reg #(.W(W), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_rise (
    .clk(clk), .rst(rst), .en(en), .d(pin_in), .q(rise_q));
  ddr_edge_reg #(.W(W), .NEG_EDGE(1'b1), .SYNC_RST(SYNC_RST)) u_fall (
    .clk(clk), .rst(rst), .en(en), .d(pin_in), .q(fall_q));

  generate
    if (ALIGN == ALIGN_OPP) begin : g_opp
      assign pair_out = {fall_q, rise_q};
    end else if (ALIGN == ALIGN_SAME) begin : g_same
      logic [W-1:0] fall_h;
      ddr_edge_reg #(.W(W), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_fall_h (
        .clk(clk), .rst(rst), .en(en), .d(fall_q), .q(fall_h));
      assign pair_out = {fall_h, rise_q};
    end else begin : g_pipe
      logic [PW-1:0] pair_h;
      ddr_edge_reg #(.W(PW), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_pair_h (
        .clk(clk), .rst(rst), .en(en), .d({fall_q, rise_q}), .q(pair_h));
      assign pair_out = pair_h;
    end
  endgenerate

  logic [1:0] live_q;
  always_ff @(posedge clk or posedge rst)
    if (rst) live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;

  generate
    if (ALIGN == ALIGN_PIPE) begin : g_chk_pipe
      AST_IN_PIPE_LAG: assert property (@(posedge clk) disable iff (rst)
        (live_q >= 2'd2 && $past(en) && $past(en, 2)) |-> pair_out[W-1:0] == $past(pin_in, 2))
        else $error("pipelined capture lag wrong"); // R4
    end else begin : g_chk_direct
      AST_IN_RISE_NOW: assert property (@(posedge clk) disable iff (rst)
        (live_q >= 2'd1 && $past(en)) |-> pair_out[W-1:0] == $past(pin_in))
        else $error("rising sample not direct"); // R2 R3
    end
  endgenerate
endmodule

// File: rtl/ddr_launch.sv
module ddr_launch
  import ddr_align_pkg::*;
#(
  parameter int     W        = 4,
  parameter align_e ALIGN    = ALIGN_SAME,
  parameter bit     SYNC_RST = 1'b0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           en,
  input  logic [2*W-1:0] pair_in,
  output logic [W-1:0]   pin_out
);
  localparam int PW = 2 * W;

  logic [W-1:0] first_q, second_q;

  generate
    if (ALIGN == ALIGN_OPP) begin : g_opp
      ddr_edge_reg #(.W(W), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_first (
        .clk(clk), .rst(rst), .en(en), .d(pair_in[W-1:0]), .q(first_q));
      ddr_edge_reg #(.W(W), .NEG_EDGE(1'b1), .SYNC_RST(SYNC_RST)) u_second (
        .clk(clk), .rst(rst), .en(en), .d(pair_in[PW-1:W]), .q(second_q));
    end else if (ALIGN == ALIGN_SAME) begin : g_same
      ddr_edge_reg #(.W(PW), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_both (
        .clk(clk), .rst(rst), .en(en), .d(pair_in), .q({second_q, first_q}));
    end else begin : g_pipe
      logic [PW-1:0] stage_q;
      ddr_edge_reg #(.W(PW), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_stage (
        .clk(clk), .rst(rst), .en(en), .d(pair_in), .q(stage_q));
      ddr_edge_reg #(.W(PW), .NEG_EDGE(1'b0), .SYNC_RST(SYNC_RST)) u_both (
        .clk(clk), .rst(rst), .en(en), .d(stage_q), .q({second_q, first_q}));
    end
  endgenerate

  assign pin_out = clk ? first_q : second_q;

  logic [1:0] live_q;
  always_ff @(posedge clk or posedge rst)
    if (rst) live_q <= '0;
    else if (live_q != 2'd3) live_q <= live_q + 2'd1;

  generate
    if (ALIGN == ALIGN_SAME) begin : g_chk_same
      AST_OUT_SAME_LOW: assert property (@(posedge clk) disable iff (rst)
        (live_q >= 2'd1 && $past(en)) |-> pin_out == $past(pair_in[PW-1:W]))
        else $error("same-edge low phase wrong"); // R6
    end else if (ALIGN == ALIGN_PIPE) begin : g_chk_pipe
      AST_OUT_PIPE_LOW: assert property (@(posedge clk) disable iff (rst)
        (live_q >= 2'd2 && $past(en) && $past(en, 2)) |-> pin_out == $past(pair_in[PW-1:W], 2))
        else $error("pipelined low phase wrong"); // R7
    end
  endgenerate
endmodule

// File: rtl/ddr_align_io.sv
module ddr_align_io
  import ddr_align_pkg::*;
#(
  parameter int     W         = 4,
  parameter align_e IN_ALIGN  = ALIGN_PIPE,
  parameter align_e OUT_ALIGN = ALIGN_SAME,
  parameter bit     SYNC_RST  = 1'b0,
  parameter bit     USE_CE    = 1'b1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           ce,
  input  logic [W-1:0]   pin_in,
  output logic [2*W-1:0] rx_pair,
  input  logic [2*W-1:0] tx_pair,
  output logic [W-1:0]   pin_out
);
  logic en;
  assign en = ce | !USE_CE;

  ddr_capture #(.W(W), .ALIGN(IN_ALIGN), .SYNC_RST(SYNC_RST)) u_capture (
    .clk(clk), .rst(rst), .en(en), .pin_in(pin_in), .pair_out(rx_pair));

  ddr_launch #(.W(W), .ALIGN(OUT_ALIGN), .SYNC_RST(SYNC_RST)) u_launch (
    .clk(clk), .rst(rst), .en(en), .pair_in(tx_pair), .pin_out(pin_out));
endmodule

// File: tb/ddr_align_io_tb_top.sv
`timescale 1ns/100ps
module ddr_align_io_tb_top;
  import ddr_align_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst, ce;
  logic [3:0] pin_in;
  logic [7:0] tx_pair;
  logic [7:0] rx_i, rx_o, rx_a;
  logic [3:0] po_i, po_o, po_a;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  // defaults: pipelined in, same-edge out, async reset, ce honoured (R12)
  ddr_align_io dut_i (.clk(clk), .rst(rst), .ce(ce), .pin_in(pin_in),
    .rx_pair(rx_i), .tx_pair(tx_pair), .pin_out(po_i));
  ddr_align_io #(.W(4), .IN_ALIGN(ALIGN_OPP), .OUT_ALIGN(ALIGN_OPP),
    .SYNC_RST(1'b0), .USE_CE(1'b0)) dut_opp (.clk(clk), .rst(rst), .ce(ce),
    .pin_in(pin_in), .rx_pair(rx_o), .tx_pair(tx_pair), .pin_out(po_o));
  ddr_align_io #(.W(4), .IN_ALIGN(ALIGN_SAME), .OUT_ALIGN(ALIGN_PIPE),
    .SYNC_RST(1'b1), .USE_CE(1'b1)) dut_alt (.clk(clk), .rst(rst), .ce(ce),
    .pin_in(pin_in), .rx_pair(rx_a), .tx_pair(tx_pair), .pin_out(po_a));

  function automatic logic [3:0] rv(input int k); return 4'((k * 5 + 3) % 16); endfunction
  function automatic logic [3:0] fv(input int k); return 4'((k * 11 + 6) % 16); endfunction
  function automatic logic [3:0] av(input int k); return 4'((k * 7 + 1) % 16); endfunction
  function automatic logic [3:0] bv(input int k); return 4'((k * 13 + 9) % 16); endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      finish_run();
    end
  end

  logic [7:0] srx_i, srx_a;
  logic [3:0] shi_i, shi_a, slo_i, slo_a;

  initial begin
    rst = 1'b1; ce = 1'b1; pin_in = 4'h0; tx_pair = 8'h00;
    repeat (2) @(posedge clk);
    #1.5;
    chk("R10 reset rx dut_i", rx_i, 8'h00);
    chk("R10 reset rx dut_opp", rx_o, 8'h00);
    chk("R11 reset rx dut_alt", rx_a, 8'h00);
    chk("R10 reset pin dut_i", {4'h0, po_i}, 8'h00);
    chk("R11 reset pin dut_alt", {4'h0, po_a}, 8'h00);
    @(negedge clk); #1;
    rst = 1'b0; pin_in = rv(0);

    for (int c = 0; c < 40; c++) begin
      @(posedge clk); #1;
      pin_in = fv(c); tx_pair = {bv(c), av(c)};
      #0.5;
      if (c >= 2) begin
        chk("R1/R4/R12 rx dut_i high", rx_i, {fv(c-1), rv(c-1)});
        chk("R1/R6/R12 pin dut_i high", {4'h0, po_i}, {4'h0, av(c-1)});
        chk("R2 rx dut_opp high", rx_o, {fv(c-1), rv(c)});
        chk("R5 pin dut_opp high", {4'h0, po_o}, {4'h0, av(c-1)});
        chk("R3 rx dut_alt high", rx_a, {fv(c-1), rv(c)});
        chk("R7 pin dut_alt high", {4'h0, po_a}, {4'h0, av(c-2)});
      end
      @(negedge clk); #1;
      pin_in = rv(c + 1);
      #0.5;
      if (c >= 2) begin
        chk("R4 rx dut_i low", rx_i, {fv(c-1), rv(c-1)});
        chk("R1/R6 pin dut_i low", {4'h0, po_i}, {4'h0, bv(c-1)});
        chk("R2 rx dut_opp low", rx_o, {fv(c), rv(c)});
        chk("R5 pin dut_opp low", {4'h0, po_o}, {4'h0, bv(c)});
        chk("R3 rx dut_alt low", rx_a, {fv(c-1), rv(c)});
        chk("R7 pin dut_alt low", {4'h0, po_a}, {4'h0, bv(c-2)});
      end
    end

    // clock enable low: CE instances freeze, dut_opp keeps running
    @(posedge clk); #1;
    ce = 1'b0;
    #0.5;
    srx_i = rx_i; srx_a = rx_a; shi_i = po_i; shi_a = po_a;
    @(negedge clk); #1.5;
    slo_i = po_i; slo_a = po_a;
    for (int j = 0; j < 4; j++) begin
      pin_in = 4'(9 + j); tx_pair = 8'hC3 ^ 8'(j * 17);
      @(posedge clk); #1.5;
      chk("R8 rx dut_i held", rx_i, srx_i);
      chk("R8 rx dut_alt held", rx_a, srx_a);
      chk("R8 pin dut_i high held", {4'h0, po_i}, {4'h0, shi_i});
      chk("R8 pin dut_alt high held", {4'h0, po_a}, {4'h0, shi_a});
      chk("R9 rx dut_opp rise moves", {4'h0, rx_o[3:0]}, {4'h0, 4'(9 + j)});
      @(negedge clk); #1.5;
      chk("R8 pin dut_i low held", {4'h0, po_i}, {4'h0, slo_i});
      chk("R8 pin dut_alt low held", {4'h0, po_a}, {4'h0, slo_a});
      chk("R9 rx dut_opp fall moves", {4'h0, rx_o[7:4]}, {4'h0, 4'(9 + j)});
    end
    ce = 1'b1;

    // reset type: async clears at once, sync waits for the edge
    pin_in = 4'hA; tx_pair = 8'h5A;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b1;
    #0.5;
    chk("R10 async rx cleared at once", rx_i, 8'h00);
    chk("R10 async pin cleared at once", {4'h0, po_i}, 8'h00);
    chk("R11 sync rx not yet cleared", rx_a, 8'hAA);
    chk("R11 sync pin not yet cleared", {4'h0, po_a}, 8'h0A);
    @(negedge clk); #1.5;
    chk("R11 sync rx before rising edge", rx_a, 8'hAA);
    chk("R11 sync pin low before rising edge", {4'h0, po_a}, 8'h05);
    @(posedge clk); #1.5;
    chk("R11 sync rx cleared", rx_a, 8'h00);
    chk("R11 sync pin cleared", {4'h0, po_a}, 8'h00);
    chk("R10 async opp rx cleared", rx_o, 8'h00);
    chk("R10 async opp pin cleared", {4'h0, po_o}, 8'h00);
    @(negedge clk); #1;
    rst = 1'b0;
    @(posedge clk); #1.5;
    chk("R10/R4 pipeline stage cleared", rx_i, 8'h00);
    chk("R10/R7 output stage cleared", {4'h0, po_a}, 8'h00);
    chk("R3 rise after release", rx_a, 8'h0A);
    @(posedge clk); #1.5;
    chk("R4 pipeline refilled", rx_i, 8'hAA);
    chk("R7 output stage refilled", {4'h0, po_a}, 8'h0A);

    finish_run();
  end
endmodule